// File: doc/BRIEF.md
# DMA Channel Control-Status Register

This block holds the control and status word of one descriptor-driven DMA channel. Software reaches it through full 32-bit register writes and reads. The word carries the channel's run, completion, interrupt, idle, stall and fault flags, a group of freely writable configuration bits, and two command bits that are never stored.

The transfer engine beside it receives a one-cycle start pulse when software moves the run flag from 0 to 1. The engine reports back three things: a finished control block (with that block's interrupt-enable), a finished chain, and its stall and fault conditions. The channel interrupt line is driven straight from the stored interrupt flag.

The flag that clears on a write of 1, the flag that the engine sets and the command bits all share one word. The rules below fix what happens when software writes and the engine reports in the same cycle.

Top module: `dma_cs_reg`

## Requirements
- R1: After reset the register reads 0x00000000, and both `irq` and `start_o` are low.
- R2: A write replaces only the bits set in mask 0x30FF0001 (bit 0, bits 16..23, bits 28..29). Every other bit keeps its current value.
- R3: Writing 1 to bit 1 (block-end flag) clears it. Writing 0 there leaves it unchanged.
- R4: Writing 1 to bit 2 (interrupt flag) clears it, and `irq` goes low in the same cycle that the read value changes. `irq` is high exactly while bit 2 reads 1.
- R5: Writing 1 to bit 31 first clears every flag, including bits 4, 5 and 8. Any engine indication in that cycle is discarded. The masked bits of the same write are then applied. Bit 31 always reads 0.
- R6: A write that takes bit 0 (run) from 0 to 1 raises `start_o` for exactly one cycle, visible with the new register value, and clears bit 4. Writing 1 to bit 0 while it is already 1 gives no pulse.
- R7: Bit 30 (abort) has no effect of its own and always reads 0.
- R8: `cb_done` sets bit 1. When `cb_int_en` is also high, it sets bit 2 and raises `irq`.
- R9: `chain_done` while bit 0 is 1 clears bit 0 and sets bit 4 (idle). `chain_done` while bit 0 is 0 is ignored.
- R10: Bit 5 follows `eng_held` one cycle later. `eng_err` sets bit 8, which stays set until a bit-31 write.
- R11: When an engine set of bit 1 or bit 2 meets a write-1-to-clear of the same bit in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| cb_done | input | 1 | Engine finished one control block |
| cb_int_en | input | 1 | Interrupt enable of the finished block |
| chain_done | input | 1 | Engine reached the end of the chain |
| eng_held | input | 1 | Engine stalled by flow control |
| eng_err | input | 1 | Engine fault pulse |
| start_o | output | 1 | One-cycle start pulse to the engine |
| irq | output | 1 | Channel interrupt line |

## Verification
The hardest cases to reach are the cycles where a software write and an engine report land on the same clock edge. Examples are a clear of the interrupt flag against a new block completion, or a channel-reset write that also sets the run bit while the engine reports. The stimulus drives these collisions on purpose, one cycle at a time. It also restarts the channel from the idle state, so that the clearing of the idle flag on start is seen.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;
    localparam int REG_W  = 32;
    localparam int B_ACT  = 0;
    localparam int B_END  = 1;
    localparam int B_INT  = 2;
    localparam int B_IDLE = 4;
    localparam int B_HELD = 5;
    localparam int B_ERR  = 8;
    localparam int B_ABT  = 30;
    localparam int B_RST  = 31;
    localparam logic [REG_W-1:0] WR_MASK_DEF = 32'h30FF_0001;

    typedef struct packed {
        logic [REG_W-1:0] cs;
        logic             start;
    } cs_state_t;
endpackage

// File: rtl/dma_cs_wdec.sv
module dma_cs_wdec
    import dma_cs_pkg::*;
#(
    parameter int               W       = REG_W,
    parameter logic [W-1:0]     WR_MASK = WR_MASK_DEF
) (
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         do_rst,
    output logic         clr_end,
    output logic         clr_int,
    output logic [W-1:0] keep_bits,
    output logic [W-1:0] new_bits
);
    localparam logic [W-1:0] KEEP = ~WR_MASK;

    always_comb begin
        do_rst    = wr_en && wr_data[B_RST];
        clr_end   = wr_en && wr_data[B_END];
        clr_int   = wr_en && wr_data[B_INT];
        keep_bits = wr_en ? KEEP : '1;
        new_bits  = wr_en ? (wr_data & WR_MASK) : '0;
    end
endmodule

// File: rtl/dma_cs_evt.sv
module dma_cs_evt (
    input  logic cb_done,
    input  logic cb_int_en,
    input  logic chain_done,
    input  logic eng_held,
    input  logic eng_err,
    input  logic active_q,
    input  logic squash,
    output logic set_end,
    output logic set_int,
    output logic finish,
    output logic set_err,
    output logic held
);
    always_comb begin
        set_end = !squash && cb_done;
        set_int = !squash && cb_done && cb_int_en;
        finish  = !squash && chain_done && active_q;
        set_err = !squash && eng_err;
        held    = !squash && eng_held;
    end
endmodule

// File: rtl/dma_cs_reg.sv
module dma_cs_reg
    import dma_cs_pkg::*;
#(
    parameter logic [REG_W-1:0] WR_MASK = WR_MASK_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             cb_done,
    input  logic             cb_int_en,
    input  logic             chain_done,
    input  logic             eng_held,
    input  logic             eng_err,
    output logic             start_o,
    output logic             irq
);
    cs_state_t state_d, state_q;

    logic             do_rst, clr_end, clr_int;
    logic [REG_W-1:0] keep_bits, new_bits;
    logic             set_end, set_int, finish, set_err, held;

    dma_cs_wdec #(.W(REG_W), .WR_MASK(WR_MASK)) wdec_i (
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .do_rst    (do_rst),
        .clr_end   (clr_end),
        .clr_int   (clr_int),
        .keep_bits (keep_bits),
        .new_bits  (new_bits)
    );

    dma_cs_evt evt_i (
        .cb_done    (cb_done),
        .cb_int_en  (cb_int_en),
        .chain_done (chain_done),
        .eng_held   (eng_held),
        .eng_err    (eng_err),
        .active_q   (state_q.cs[B_ACT]),
        .squash     (do_rst),
        .set_end    (set_end),
        .set_int    (set_int),
        .finish     (finish),
        .set_err    (set_err),
        .held       (held)
    );

    always_comb begin
        logic [REG_W-1:0] nx;
        nx = state_q.cs;
        // channel reset first, then clear-on-one, then masked replace
        if (do_rst)  nx = '0;
        if (clr_end) nx[B_END] = 1'b0;
        if (clr_int) nx[B_INT] = 1'b0;
        nx = (nx & keep_bits) | new_bits;
        state_d.start = wr_en && !state_q.cs[B_ACT] && nx[B_ACT];
        // engine reports override the software clears of this cycle
        if (set_end) nx[B_END] = 1'b1;
        if (set_int) nx[B_INT] = 1'b1;
        if (set_err) nx[B_ERR] = 1'b1;
        if (finish) begin
            nx[B_ACT]  = 1'b0;
            nx[B_IDLE] = 1'b1;
        end
        nx[B_HELD] = held;
        if (state_d.start) nx[B_IDLE] = 1'b0;
        nx[B_RST] = 1'b0;
        nx[B_ABT] = 1'b0;
        state_d.cs = nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_data = state_q.cs;
    assign start_o = state_q.start;
    assign irq     = state_q.cs[B_INT];
endmodule

// File: rtl/dma_cs_chk.sv
module dma_cs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        cb_done,
    input logic        cb_int_en,
    input logic        chain_done,
    input logic        start_o,
    input logic        irq
);
    // R6
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R6
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0] && !rd_data[0]) |=> start_o);

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(cb_done && cb_int_en) && !(wr_en && wr_data[31])) |=> !irq);

    // R5
    chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31]) |=> (rd_data[2:1] == 2'b00 && rd_data[8] == 1'b0
                                    && rd_data[5:4] == 2'b00 && !irq));

    // R7
    cmd_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[31:30] == 2'b00);

    // R9
    run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !chain_done && !wr_en) |=> rd_data[0]);
endmodule

bind dma_cs_reg dma_cs_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .cb_done    (cb_done),
    .cb_int_en  (cb_int_en),
    .chain_done (chain_done),
    .start_o    (start_o),
    .irq        (irq)
);

// File: tb/dma_cs_reg_tb.sv
`timescale 1ns/1ps
module dma_cs_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        cb_done = 1'b0, cb_int_en = 1'b0, chain_done = 1'b0;
    logic        eng_held = 1'b0, eng_err = 1'b0;
    logic [31:0] rd_data;
    logic        start_o, irq;

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    dma_cs_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cb_done(cb_done), .cb_int_en(cb_int_en),
        .chain_done(chain_done), .eng_held(eng_held), .eng_err(eng_err),
        .start_o(start_o), .irq(irq)
    );

    // behavioural reference
    logic [31:0] m_cs = '0;
    bit          m_st = 0;
    always @(posedge clk or negedge rst_n) begin
        logic [31:0] nv;
        bit          go;
        bit          wipe;
        if (!rst_n) begin
            m_cs = '0;
            m_st = 0;
        end else begin
            wipe = wr_en && wr_data[31];
            nv = wipe ? 32'h0 : m_cs;
            if (wr_en && wr_data[1]) nv[1] = 0;
            if (wr_en && wr_data[2]) nv[2] = 0;
            if (wr_en) begin
                nv[0] = wr_data[0];
                for (int b = 16; b < 24; b++) nv[b] = wr_data[b];
                nv[28] = wr_data[28];
                nv[29] = wr_data[29];
            end
            go = wr_en && (m_cs[0] == 0) && (nv[0] == 1);
            nv[5] = 0;
            if (!wipe) begin
                if (cb_done) nv[1] = 1;
                if (cb_done && cb_int_en) nv[2] = 1;
                if (eng_err) nv[8] = 1;
                if (chain_done && m_cs[0]) begin nv[0] = 0; nv[4] = 1; end
                nv[5] = eng_held;
            end
            if (go) nv[4] = 0;
            m_cs = nv;
            m_st = go;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rd_data, m_cs, {cur_req, " model rd_data"});
            chk({31'd0, irq}, {31'd0, m_cs[2]}, {cur_req, " model irq"});
            chk({31'd0, start_o}, {31'd0, m_st}, {cur_req, " model start"});
        end
    end

    task automatic step(input logic w, input logic [31:0] d, input logic cbd,
                        input logic ie, input logic cd, input logic er);
        @(negedge clk);
        wr_en = w; wr_data = d; cb_done = cbd; cb_int_en = ie;
        chain_done = cd; eng_err = er;
        @(negedge clk);
        wr_en = 0; wr_data = '0; cb_done = 0; cb_int_en = 0;
        chain_done = 0; eng_err = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(rd_data, 32'h0, "R1 reset value");
        chk({31'd0, irq}, 32'h0, "R1 irq low");
        chk({31'd0, start_o}, 32'h0, "R1 start low");

        cur_req = "R7";
        step(1, 32'h600A_0000, 0, 0, 0, 0);
        chk(rd_data, 32'h200A_0000, "R7 abort ignored, R2 masked write");
        chk({31'd0, start_o}, 32'h0, "R7 no start");

        cur_req = "R6";
        step(1, 32'h0000_0001, 0, 0, 0, 0);
        chk(rd_data, 32'h0000_0001, "R2 masked replace on start");
        chk({31'd0, start_o}, 32'h1, "R6 start pulse");
        @(negedge clk);
        chk({31'd0, start_o}, 32'h0, "R6 pulse one cycle");
        step(1, 32'h0000_0001, 0, 0, 0, 0);
        chk({31'd0, start_o}, 32'h0, "R6 rewrite no pulse");

        cur_req = "R8";
        step(0, 0, 1, 0, 0, 0);
        chk(rd_data, 32'h3, "R8 block end, no int");
        chk({31'd0, irq}, 32'h0, "R8 irq low");
        step(0, 0, 1, 1, 0, 0);
        chk(rd_data, 32'h7, "R8 block end with int");
        chk({31'd0, irq}, 32'h1, "R8 irq high");

        cur_req = "R3";
        step(1, 32'h3, 0, 0, 0, 0);
        chk(rd_data, 32'h5, "R3 end cleared");
        cur_req = "R4";
        step(1, 32'h5, 0, 0, 0, 0);
        chk(rd_data, 32'h1, "R4 int cleared");
        chk({31'd0, irq}, 32'h0, "R4 irq dropped");

        cur_req = "R9";
        step(0, 0, 0, 0, 1, 0);
        chk(rd_data, 32'h10, "R9 chain finish");
        step(0, 0, 0, 0, 1, 0);
        chk(rd_data, 32'h10, "R9 finish ignored when idle");

        cur_req = "R10";
        @(negedge clk); eng_held = 1;
        @(negedge clk);
        chk(rd_data, 32'h30, "R10 held shown");
        eng_held = 0;
        @(negedge clk);
        chk(rd_data, 32'h10, "R10 held released");
        step(0, 0, 0, 0, 0, 1);
        chk(rd_data, 32'h110, "R10 error sticky set");
        repeat (3) @(negedge clk);
        chk(rd_data, 32'h110, "R10 error stays");

        cur_req = "R11";
        step(1, 32'h6, 1, 1, 0, 0);
        chk(rd_data, 32'h116, "R11 engine set wins");
        chk({31'd0, irq}, 32'h1, "R11 irq stays");

        cur_req = "R5";
        step(1, 32'h8000_0001, 1, 1, 0, 0);
        chk(rd_data, 32'h1, "R5 reset then masked write");
        chk({31'd0, start_o}, 32'h1, "R5 start after reset write");
        chk({31'd0, irq}, 32'h0, "R5 irq cleared");

        cur_req = "R6";
        step(0, 0, 0, 0, 1, 0);
        chk(rd_data, 32'h10, "R9 idle before restart");
        step(1, 32'h0011_0001, 0, 0, 0, 0);
        chk(rd_data, 32'h0011_0001, "R6 restart clears idle");
        chk({31'd0, start_o}, 32'h1, "R6 restart pulse");
        cur_req = "R2";
        step(1, 32'h0FFF_FFF9, 0, 0, 0, 0);
        chk(rd_data, 32'h00FF_0001, "R2 unmasked bits untouched");

        repeat (2) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule